// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter with Alarm

This block keeps wall-clock time from a one-second tick. Seconds, minutes and hours are held as two-digit BCD bytes. The date is a plain binary day count of `DAY_W` bits, 15 by default. Software reaches everything through a byte-wide register port with an 8-bit address. That port has a write strobe with its data, and a read path that returns the addressed register on the same cycle.

A tick does not update every field at once. A small sequencer walks the carry one field per clock: seconds, then minutes, then hours, then the day count. While this walk is in progress, a busy bit in the control register reads 1. If software writes a time register during that window, the write is parked in a one-entry slot and applied once the walk ends. An alarm compares the current minute, hour and day against programmed values, each field with its own enable. The compare is made when a new minute begins. On a match the block sets a sticky flag, and the flag drives an interrupt pin when the interrupt enable is set.

The register port and the interrupt are plain control and status signals. There is no data stream, so no valid/ready handshake is used and no back-pressure applies.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds (address 0x15) and minutes (0x16) count in BCD. A field at 0x59 goes to 0x00 on its update and carries one into the next field; any other value advances by one BCD step.
- R2: Hours (0x17) count in BCD up to 0x23. From 0x23 they return to 0x00 and increment the day count.
- R3: The day count is binary. Its low byte is at 0x18 and its upper bits are at 0x19, where the unused top bit reads 0. It wraps from all ones (0x7FFF) to zero.
- R4: Control register 0x14 holds the calendar enable in bit 0. When that bit is 0, ticks are ignored and no field changes.
- R5: Control bit 7 is read-only and reads 1 while a tick's carry is being propagated. A time write (0x15 to 0x19) made while busy is held and applied after propagation, so it is not lost and not incremented.
- R6: The alarm registers are minute 0x1A, hour 0x1B, day low 0x1C and day high 0x1D. The field enables are control bit 5 (day), bit 4 (hour) and bit 3 (minute). When a tick update leaves seconds at 0x00 and every enabled field equals its alarm value, the alarm flag (control bit 2) sets. With no enable set, the flag never sets.
- R7: Writing 1 to control bit 2 clears the alarm flag. Writing 0 to it leaves the flag unchanged.
- R8: The `alarm_irq_o` pin equals the alarm flag AND the interrupt enable (control bit 1).
- R9: A software write to a time field changes only that field and produces no carry into the next one.
- R10: Non-BCD values still count. A low digit of 9 or above becomes 0 and the upper digit increments, so 0x0A advances to 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (8) | Register address, used for both reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the register at `addr_i` |
| alarm_irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench drives the full carry chain from 23:59:59, and also across the top of the day count. A design that dropped the carry into the day, or failed to mask the day width, would read the wrong day bytes.

It injects a seconds write in the middle of a carry walk. A design that applied that write immediately, or dropped it, would end with a seconds value other than the one written.

The alarm flag is exercised three ways:
- with one enable set, with several enables set, and with none set;
- under the write-0 and write-1 clear rules;
- with the interrupt enable off.

A design that ignored an enable, or cleared the flag on a 0 write, would show a wrong control byte or a wrong interrupt pin. Non-BCD seconds catch an incrementer that adds one in binary instead of taking the BCD step.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SEC, ST_MIN, ST_HR, ST_DAY} step_e;

  localparam logic [7:0] A_CTRL = 8'h14;
  localparam logic [7:0] A_SEC  = 8'h15;
  localparam logic [7:0] A_MIN  = 8'h16;
  localparam logic [7:0] A_HR   = 8'h17;
  localparam logic [7:0] A_DAYL = 8'h18;
  localparam logic [7:0] A_DAYH = 8'h19;
  localparam logic [7:0] A_AMIN = 8'h1A;
  localparam logic [7:0] A_AHR  = 8'h1B;
  localparam logic [7:0] A_ADL  = 8'h1C;
  localparam logic [7:0] A_ADH  = 8'h1D;

  localparam logic [7:0] MS_WRAP = 8'h59;
  localparam logic [7:0] HR_WRAP = 8'h23;
  localparam int         N_TF    = 3;
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
  parameter logic [7:0] WRAP = 8'h59
) (
  input  logic [7:0] cur_i,
  output logic [7:0] nxt_o,
  output logic       wrap_o
);
  always_comb begin
    wrap_o = (cur_i == WRAP);
    if (wrap_o)
      nxt_o = 8'h00;
    else if (cur_i[3:0] >= 4'd9)
      nxt_o = {cur_i[7:4] + 4'd1, 4'd0};
    else
      nxt_o = {cur_i[7:4], cur_i[3:0] + 4'd1};
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int DAY_W = 15
) (
  input  logic [7:0]       min_i,
  input  logic [7:0]       hr_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [7:0]       amin_i,
  input  logic [7:0]       ahr_i,
  input  logic [DAY_W-1:0] aday_i,
  input  logic             men_i,
  input  logic             hen_i,
  input  logic             den_i,
  output logic             hit_o
);
  logic any_en;
  always_comb begin
    any_en = men_i | hen_i | den_i;
    hit_o  = any_en
           & (~men_i | (min_i == amin_i))
           & (~hen_i | (hr_i  == ahr_i))
           & (~den_i | (day_i == aday_i));
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          alarm_irq_o
);
  localparam int HI_W = DAY_W - 8;

  logic [7:0]       tf_q   [N_TF];
  logic [7:0]       tf_nxt [N_TF];
  logic [N_TF-1:0]  tf_wrap;
  logic [DAY_W-1:0] day_q, aday_q;
  logic [7:0]       amin_q, ahr_q;
  logic             cal_en_q, aie_q, flag_q, men_q, hen_q, den_q;
  step_e            st_q, st_d;
  logic             done_q, busy, hit, set_al, clr_al;
  logic             pend_v_q;
  logic [AW-1:0]    pend_a_q;
  logic [7:0]       pend_d_q;
  logic             is_time, hold_wr, direct_wr, apply_pend, tw_v;
  logic [AW-1:0]    tw_a;
  logic [7:0]       tw_d;

  for (genvar g = 0; g < N_TF; g++) begin : g_step
    rtc_bcd_step #(.WRAP(g == N_TF-1 ? HR_WRAP : MS_WRAP)) u_step (
      .cur_i(tf_q[g]), .nxt_o(tf_nxt[g]), .wrap_o(tf_wrap[g]));
  end

  rtc_alarm_cmp #(.DAY_W(DAY_W)) u_cmp (
    .min_i(tf_q[1]), .hr_i(tf_q[2]), .day_i(day_q),
    .amin_i(amin_q), .ahr_i(ahr_q), .aday_i(aday_q),
    .men_i(men_q), .hen_i(hen_q), .den_i(den_q), .hit_o(hit));

  assign busy = (st_q != ST_IDLE);

  always_comb begin
    is_time    = (addr_i >= AW'(A_SEC)) && (addr_i <= AW'(A_DAYH));
    hold_wr    = wr_en_i && is_time && (busy || pend_v_q);
    direct_wr  = wr_en_i && is_time && !busy && !pend_v_q;
    apply_pend = pend_v_q && !busy;
    tw_v       = direct_wr || apply_pend;
    tw_a       = apply_pend ? pend_a_q : addr_i;
    tw_d       = apply_pend ? pend_d_q : wdata_i;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (tick_i && cal_en_q) st_d = ST_SEC;
      ST_SEC:  st_d = tf_wrap[0] ? ST_MIN : ST_IDLE;
      ST_MIN:  st_d = tf_wrap[1] ? ST_HR  : ST_IDLE;
      ST_HR:   st_d = tf_wrap[2] ? ST_DAY : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      pend_v_q <= 1'b0;
      pend_a_q <= '0;
      pend_d_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= busy && (st_d == ST_IDLE);
      if (hold_wr) begin
        pend_v_q <= 1'b1;
        pend_a_q <= addr_i;
        pend_d_q <= wdata_i;
      end else if (apply_pend) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TF; i++) tf_q[i] <= 8'h00;
      day_q <= '0;
    end else begin
      unique case (st_q)
        ST_SEC:  tf_q[0] <= tf_nxt[0];
        ST_MIN:  tf_q[1] <= tf_nxt[1];
        ST_HR:   tf_q[2] <= tf_nxt[2];
        ST_DAY:  day_q   <= day_q + {{(DAY_W-1){1'b0}}, 1'b1};
        default: ;
      endcase
      if (tw_v) begin
        if (tw_a == AW'(A_SEC))  tf_q[0] <= tw_d;
        if (tw_a == AW'(A_MIN))  tf_q[1] <= tw_d;
        if (tw_a == AW'(A_HR))   tf_q[2] <= tw_d;
        if (tw_a == AW'(A_DAYL)) day_q[7:0] <= tw_d;
        if (tw_a == AW'(A_DAYH)) day_q[DAY_W-1:8] <= tw_d[HI_W-1:0];
      end
    end
  end

  assign set_al = done_q && (tf_q[0] == 8'h00) && hit;
  assign clr_al = wr_en_i && (addr_i == AW'(A_CTRL)) && wdata_i[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_en_q <= 1'b0; aie_q <= 1'b0; flag_q <= 1'b0;
      men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0;
      amin_q <= '0; ahr_q <= '0; aday_q <= '0;
    end else begin
      flag_q <= set_al || (flag_q && !clr_al);
      if (wr_en_i) begin
        if (addr_i == AW'(A_CTRL)) begin
          cal_en_q <= wdata_i[0];
          aie_q    <= wdata_i[1];
          men_q    <= wdata_i[3];
          hen_q    <= wdata_i[4];
          den_q    <= wdata_i[5];
        end
        if (addr_i == AW'(A_AMIN)) amin_q <= wdata_i;
        if (addr_i == AW'(A_AHR))  ahr_q  <= wdata_i;
        if (addr_i == AW'(A_ADL))  aday_q[7:0] <= wdata_i;
        if (addr_i == AW'(A_ADH))  aday_q[DAY_W-1:8] <= wdata_i[HI_W-1:0];
      end
    end
  end

  assign alarm_irq_o = flag_q & aie_q;

  always_comb begin
    rdata_o = 8'h00;
    unique case (addr_i)
      AW'(A_CTRL): rdata_o = {busy, 1'b0, den_q, hen_q, men_q, flag_q, aie_q, cal_en_q};
      AW'(A_SEC):  rdata_o = tf_q[0];
      AW'(A_MIN):  rdata_o = tf_q[1];
      AW'(A_HR):   rdata_o = tf_q[2];
      AW'(A_DAYL): rdata_o = day_q[7:0];
      AW'(A_DAYH): rdata_o[HI_W-1:0] = day_q[DAY_W-1:8];
      AW'(A_AMIN): rdata_o = amin_q;
      AW'(A_AHR):  rdata_o = ahr_q;
      AW'(A_ADL):  rdata_o = aday_q[7:0];
      AW'(A_ADH):  rdata_o[HI_W-1:0] = aday_q[DAY_W-1:8];
      default:     rdata_o = 8'h00;
    endcase
  end

  // R2
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HR && tf_q[2] == HR_WRAP) |=> (tf_q[2] == 8'h00 && st_q == ST_DAY));
  // R3
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAY && (&day_q) && !tw_v) |=> (day_q == '0));
  // R4
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !cal_en_q) |=> (st_q == ST_IDLE));
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tick_i && cal_en_q) |=> (rdata_o[7] || addr_i != AW'(A_CTRL)) && st_q == ST_SEC);
  // R6
  no_enable_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!men_q && !hen_q && !den_q) |=> !$rose(flag_q));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_al && !done_q) |=> !flag_q);
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       alarm_irq_o;
  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  rtc_bcd_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .alarm_irq_o(alarm_irq_o));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(8'h17, h); wr(8'h16, m); wr(8'h15, s);
  endtask

  task automatic t_reset();
    rd("R4 reset ctrl", 8'h14, 8'h00);
    rd("R1 reset sec", 8'h15, 8'h00);
    n_chk++;
    if (alarm_irq_o !== 1'b0) begin n_bad++; $display("FAIL R8 reset irq: got %b expected 0", alarm_irq_o); end
  endtask

  task automatic t_sec_min();
    wr(8'h14, 8'h01);
    set_time(8'h07, 8'h12, 8'h58);
    tick(); rd("R1 sec step", 8'h15, 8'h59);
    tick(); rd("R1 sec wrap", 8'h15, 8'h00);
    rd("R1 min carry", 8'h16, 8'h13);
    set_time(8'h07, 8'h59, 8'h59);
    tick(); rd("R1 min wrap", 8'h16, 8'h00);
    rd("R2 hour carry", 8'h17, 8'h08);
  endtask

  task automatic t_hour_day();
    wr(8'h18, 8'hFF); wr(8'h19, 8'h00);
    set_time(8'h23, 8'h59, 8'h59);
    tick();
    rd("R2 hour wrap", 8'h17, 8'h00);
    rd("R3 day low", 8'h18, 8'h00);
    rd("R3 day high", 8'h19, 8'h01);
  endtask

  task automatic t_day_wrap();
    wr(8'h18, 8'hFF); wr(8'h19, 8'hFF);
    rd("R3 high top bit", 8'h19, 8'h7F);
    set_time(8'h23, 8'h59, 8'h59);
    tick();
    rd("R3 wrap low", 8'h18, 8'h00);
    rd("R3 wrap high", 8'h19, 8'h00);
  endtask

  task automatic t_disabled();
    wr(8'h14, 8'h00);
    wr(8'h15, 8'h30);
    tick();
    rd("R4 no advance", 8'h15, 8'h30);
  endtask

  task automatic t_busy();
    wr(8'h14, 8'h01);
    set_time(8'h05, 8'h59, 8'h59);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; addr_i = 8'h14;
    #1 check("R5 busy bit", rdata_o, 8'h81);
    wr_en_i = 1'b1; addr_i = 8'h15; wdata_i = 8'h33;
    @(negedge clk); wr_en_i = 1'b0;
    repeat (6) @(negedge clk);
    rd("R5 held write", 8'h15, 8'h33);
    rd("R5 carry done min", 8'h16, 8'h00);
    rd("R5 carry done hr", 8'h17, 8'h06);
    rd("R5 busy clear", 8'h14, 8'h01);
  endtask

  task automatic t_nocarry();
    set_time(8'h04, 8'h10, 8'h00);
    wr(8'h15, 8'h59);
    wr(8'h17, 8'h23);
    repeat (4) @(negedge clk);
    rd("R9 min kept", 8'h16, 8'h10);
    rd("R9 hr written", 8'h17, 8'h23);
  endtask

  task automatic t_invalid();
    wr(8'h15, 8'h0A);
    tick(); rd("R10 0A step", 8'h15, 8'h10);
    wr(8'h15, 8'h3C);
    tick(); rd("R10 3C step", 8'h15, 8'h40);
  endtask

  task automatic t_alarm();
    wr(8'h1A, 8'h05);
    wr(8'h14, 8'h0B);
    set_time(8'h02, 8'h04, 8'h59);
    tick();
    rd("R6 minute match", 8'h14, 8'h0F);
    n_chk++;
    if (alarm_irq_o !== 1'b1) begin n_bad++; $display("FAIL R8 irq on: got %b expected 1", alarm_irq_o); end
    wr(8'h14, 8'h0B);
    rd("R7 write0 keeps", 8'h14, 8'h0F);
    wr(8'h14, 8'h0F);
    rd("R7 write1 clears", 8'h14, 8'h0B);
    n_chk++;
    if (alarm_irq_o !== 1'b0) begin n_bad++; $display("FAIL R8 irq off: got %b expected 0", alarm_irq_o); end
    wr(8'h14, 8'h09);
    set_time(8'h02, 8'h04, 8'h59);
    tick();
    rd("R8 flag no ie", 8'h14, 8'h0D);
    n_chk++;
    if (alarm_irq_o !== 1'b0) begin n_bad++; $display("FAIL R8 masked irq: got %b expected 0", alarm_irq_o); end
    wr(8'h14, 8'h0D);
  endtask

  task automatic t_alarm_miss();
    wr(8'h1B, 8'h03);
    wr(8'h14, 8'h19);
    set_time(8'h02, 8'h04, 8'h59);
    tick();
    rd("R6 hour mismatch", 8'h14, 8'h19);
    wr(8'h14, 8'h01);
    set_time(8'h02, 8'h04, 8'h59);
    tick();
    rd("R6 no enables", 8'h14, 8'h01);
    wr(8'h1C, 8'h00); wr(8'h1D, 8'h01);
    wr(8'h18, 8'hFF); wr(8'h19, 8'h00);
    wr(8'h14, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    tick();
    rd("R6 day match", 8'h14, 8'h25);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sec_min();
    t_hour_day();
    t_day_wrap();
    t_disabled();
    t_busy();
    t_nocarry();
    t_invalid();
    t_alarm();
    t_alarm_miss();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule